// File: doc/BRIEF.md
# LIN Slave Sleep and Wakeup Sequencer

This block keeps track of whether a LIN slave node is awake or asleep, and it produces the wakeup pulses the node sends onto the bus. The node is awake after reset. While awake, it counts millisecond ticks with no bus activity. When the selected idle period runs out, it raises an idle flag and goes to sleep. Software can also put the node to sleep directly. Any bus activity seen while asleep wakes the node and is reported as a received wakeup.

When software requests a wakeup, the block pulls the bus low for a programmable number of 50 µs ticks and then waits for a sync field. A sync field ends the sequence and the node stays awake. If no sync field arrives within the fixed sync-wait window, the block raises a timeout flag. It then sends the pulse again, counting the selected repeat interval from the end of the previous pulse. After the last permitted attempt times out, the node goes back to sleep.

All durations are counted on two tick inputs, so a bench can shrink them. Every pin is a plain control or status level. There is no data stream, and therefore no valid/ready handshake and no back-pressure.

Top module: `lin_slave_sleep_wake`

## Requirements
- R1: After reset, every output is low: the node is awake, no pulse is being driven, no request is pending and all flags are clear.
- R2: While awake and idle, `idle_flag` and `sleep` rise on the edge that consumes the N-th `tick_ms` since the last activity. N is (4 + 2·`idle_sel`)·MS_PER_S, where `idle_sel` is 0..3.
- R3: A cycle with `bus_active` high while awake restarts the idle count from zero. A tick that arrives in the same cycle is not counted.
- R4: A `sleep_set` pulse while awake enters sleep. While asleep, `idle_flag` never rises, however long the bus stays quiet.
- R5: While asleep, `bus_active` takes the node awake (`sleep` falls) and sets `wake_flag` on the same edge.
- R6: A `wake_req_set` pulse while awake or asleep raises `wake_pend` one edge later and starts the pulse on the following edge. `bus_drive_low` stays high for exactly `wake_len`+1 `tick_50us` ticks. `wake_flag` is set when the pulse starts, and `wake_pend` clears on the edge that ends the pulse.
- R7: A `sync_seen` after a pulse returns the node to awake. No timeout is raised and no further pulse is sent.
- R8: If no sync arrives, `timeout_flag` rises on the SYNC_WAIT_MS-th `tick_ms` after the pulse ends.
- R9: Without sync, the next pulse starts on the (REPEAT_BASE_MS + REPEAT_STEP_MS·`repeat_sel`)-th `tick_ms` after the previous pulse ends. After MAX_TRIES pulses, the node enters sleep at the sync-wait timeout of the last pulse.
- R10: `flag_clear` clears `wake_flag`, `timeout_flag` and `idle_flag`. A flag being set in the same cycle wins over the clear.
- R11: A `wake_req_set` pulse arriving while a pulse is being driven or a sync is awaited has no effect. Once the sequence ends, `wake_pend` is low and no extra pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle strobe every millisecond |
| tick_50us | input | 1 | One-cycle strobe every 50 µs |
| bus_active | input | 1 | Bus activity seen this cycle |
| sync_seen | input | 1 | A sync field was detected |
| wake_req_set | input | 1 | Software write that requests a wakeup |
| sleep_set | input | 1 | Software write that requests sleep |
| flag_clear | input | 1 | Clears the three status flags |
| idle_sel | input | 2 | Idle period select |
| repeat_sel | input | 2 | Wakeup repeat interval select |
| wake_len | input | LEN_W | Wakeup pulse length minus one, in 50 µs ticks |
| bus_drive_low | output | 1 | Pull the bus low (wakeup pulse) |
| sleep | output | 1 | Node is asleep |
| wake_pend | output | 1 | Wakeup request bit; clears itself when the pulse ends |
| wake_flag | output | 1 | A wakeup was sent or received |
| timeout_flag | output | 1 | No sync arrived after a wakeup pulse |
| idle_flag | output | 1 | The bus-idle timeout expired |

## Verification
The bench builds the block with MS_PER_S=10, SYNC_WAIT_MS=15, REPEAT_BASE_MS=18, REPEAT_STEP_MS=2 and MAX_TRIES=3, and it issues a millisecond tick every eight cycles. With these values every idle-table entry (40 to 100 ticks) can be reached, along with the full three-attempt retry sequence ending in sleep, all within a few thousand cycles. The idle and repeat formulas keep the same shape as at the default values, so the measured tick counts check the table arithmetic directly.

// File: rtl/lin_sw_pkg.sv
package lin_sw_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DRIVE = 2'd2,
    ST_WAIT  = 2'd3
  } lin_sw_state_e;
endpackage

// File: rtl/lin_sw_limits.sv
// Decodes the selectable idle period and wakeup repeat interval into tick counts.
module lin_sw_limits #(
  parameter int MS_PER_S       = 1000,
  parameter int REPEAT_BASE_MS = 180,
  parameter int REPEAT_STEP_MS = 20,
  parameter int CW             = 14
) (
  input  logic [1:0]    idle_sel,
  input  logic [1:0]    repeat_sel,
  output logic [CW-1:0] idle_lim,
  output logic [CW-1:0] rep_lim
);
  always_comb begin
    idle_lim = CW'((4 + 2 * int'(idle_sel)) * MS_PER_S);
    rep_lim  = CW'(REPEAT_BASE_MS + REPEAT_STEP_MS * int'(repeat_sel));
  end
endmodule

// File: rtl/lin_sw_tickcnt.sv
// Saturating tick counter with a synchronous clear that wins over the tick.
module lin_sw_tickcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (tick && cnt != TOP) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/lin_slave_sleep_wake.sv
module lin_slave_sleep_wake #(
  parameter int MS_PER_S       = 1000,
  parameter int SYNC_WAIT_MS   = 150,
  parameter int REPEAT_BASE_MS = 180,
  parameter int REPEAT_STEP_MS = 20,
  parameter int MAX_TRIES      = 3,
  parameter int LEN_W          = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic             tick_50us,
  input  logic             bus_active,
  input  logic             sync_seen,
  input  logic             wake_req_set,
  input  logic             sleep_set,
  input  logic             flag_clear,
  input  logic [1:0]       idle_sel,
  input  logic [1:0]       repeat_sel,
  input  logic [LEN_W-1:0] wake_len,
  output logic             bus_drive_low,
  output logic             sleep,
  output logic             wake_pend,
  output logic             wake_flag,
  output logic             timeout_flag,
  output logic             idle_flag
);
  import lin_sw_pkg::*;

  localparam int IDLE_MAX = 10 * MS_PER_S;
  localparam int REP_MAX  = REPEAT_BASE_MS + 3 * REPEAT_STEP_MS;
  localparam int CNT_MAX  = (IDLE_MAX > REP_MAX) ? IDLE_MAX : REP_MAX;
  localparam int CW       = $clog2(CNT_MAX + 1);
  localparam int TRY_W    = $clog2(MAX_TRIES + 1);
  localparam logic [CW-1:0]    SYNC_LIM = CW'(SYNC_WAIT_MS);
  localparam logic [TRY_W-1:0] TRY_LIM  = TRY_W'(MAX_TRIES);

  lin_sw_state_e    state, nxt;
  logic [CW-1:0]    ms_cnt, ms_next, idle_lim, rep_lim;
  logic [LEN_W-1:0] us_cnt;
  logic [TRY_W-1:0] tries;
  logic             ms_clr, us_clr;
  logic             set_wf, set_to, set_if, end_pulse, try_one, try_inc;

  lin_sw_limits #(
    .MS_PER_S(MS_PER_S), .REPEAT_BASE_MS(REPEAT_BASE_MS),
    .REPEAT_STEP_MS(REPEAT_STEP_MS), .CW(CW)
  ) u_lim (
    .idle_sel(idle_sel), .repeat_sel(repeat_sel),
    .idle_lim(idle_lim), .rep_lim(rep_lim)
  );

  // Shared millisecond counter: idle time while awake, time since pulse end while waiting.
  lin_sw_tickcnt #(.W(CW)) u_ms (
    .clk(clk), .rst_n(rst_n), .clr(ms_clr), .tick(tick_ms), .cnt(ms_cnt)
  );

  // Pulse-length counter, only running while the bus is driven.
  lin_sw_tickcnt #(.W(LEN_W)) u_us (
    .clk(clk), .rst_n(rst_n), .clr(us_clr), .tick(tick_50us), .cnt(us_cnt)
  );

  assign ms_next = ms_cnt + CW'(1);

  always_comb begin
    nxt       = state;
    set_wf    = 1'b0;
    set_to    = 1'b0;
    set_if    = 1'b0;
    end_pulse = 1'b0;
    try_one   = 1'b0;
    try_inc   = 1'b0;
    unique case (state)
      ST_AWAKE: begin
        if (wake_pend) begin
          nxt = ST_DRIVE; set_wf = 1'b1; try_one = 1'b1;
        end else if (sleep_set) begin
          nxt = ST_SLEEP;
        end else if (!bus_active && tick_ms && ms_next == idle_lim) begin
          nxt = ST_SLEEP; set_if = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (bus_active) begin
          nxt = ST_AWAKE; set_wf = 1'b1;
        end else if (wake_pend) begin
          nxt = ST_DRIVE; set_wf = 1'b1; try_one = 1'b1;
        end
      end
      ST_DRIVE: begin
        if (tick_50us && us_cnt == wake_len) begin
          nxt = ST_WAIT; end_pulse = 1'b1;
        end
      end
      ST_WAIT: begin
        if (sync_seen) begin
          nxt = ST_AWAKE;
        end else if (tick_ms) begin
          if (ms_next == SYNC_LIM) begin
            set_to = 1'b1;
            if (tries == TRY_LIM) nxt = ST_SLEEP;
          end
          if (ms_next == rep_lim && tries != TRY_LIM) begin
            nxt = ST_DRIVE; set_wf = 1'b1; try_inc = 1'b1;
          end
        end
      end
      default: nxt = ST_AWAKE;
    endcase
  end

  assign ms_clr = (nxt != state) || (state == ST_AWAKE && bus_active);
  assign us_clr = (state != ST_DRIVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_AWAKE;
      wake_pend    <= 1'b0;
      tries        <= '0;
      wake_flag    <= 1'b0;
      timeout_flag <= 1'b0;
      idle_flag    <= 1'b0;
    end else begin
      state <= nxt;
      if (end_pulse) wake_pend <= 1'b0;
      else if (wake_req_set && (state == ST_AWAKE || state == ST_SLEEP)) wake_pend <= 1'b1;
      if (try_one) tries <= TRY_W'(1);
      else if (try_inc) tries <= tries + TRY_W'(1);
      wake_flag    <= set_wf | (wake_flag    & ~flag_clear);
      timeout_flag <= set_to | (timeout_flag & ~flag_clear);
      idle_flag    <= set_if | (idle_flag    & ~flag_clear);
    end
  end

  assign bus_drive_low = (state == ST_DRIVE);
  assign sleep         = (state == ST_SLEEP);
endmodule

// File: rtl/lin_sw_checker.sv
module lin_sw_checker (
  input logic clk,
  input logic rst_n,
  input logic bus_active,
  input logic sync_seen,
  input logic bus_drive_low,
  input logic sleep,
  input logic wake_pend,
  input logic wake_flag,
  input logic idle_flag
);
  AST_IDLE_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_flag) |-> sleep); // R2

  AST_ASLEEP_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !idle_flag) |=> !idle_flag); // R4

  AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && bus_active) |=> (!sleep && wake_flag)); // R5

  AST_PULSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_drive_low) |-> wake_flag); // R6

  AST_PEND_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_drive_low) |-> !wake_pend); // R6

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pend && !bus_drive_low) |=> wake_pend); // R6

  AST_SYNC_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !bus_drive_low && !wake_pend && sync_seen) |=> !bus_drive_low); // R7
endmodule

bind lin_slave_sleep_wake lin_sw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_active(bus_active), .sync_seen(sync_seen),
  .bus_drive_low(bus_drive_low), .sleep(sleep), .wake_pend(wake_pend),
  .wake_flag(wake_flag), .idle_flag(idle_flag)
);

// File: tb/lin_slave_sleep_wake_bench.sv
module lin_slave_sleep_wake_bench;
  localparam int MSS = 10, SW = 15, RB = 18, RS = 2, MT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0, tick_50us = 1'b0, bus_active = 1'b0, sync_seen = 1'b0;
  logic wake_req_set = 1'b0, sleep_set = 1'b0, flag_clear = 1'b0;
  logic [1:0] idle_sel = 2'd0, repeat_sel = 2'd0;
  logic [2:0] wake_len = 3'd0;
  logic bus_drive_low, sleep, wake_pend, wake_flag, timeout_flag, idle_flag;

  int n_chk = 0, n_bad = 0, cyc = 0, ms_n = 0, us_n = 0;
  bit done = 1'b0;

  // reference model state: 0 awake, 1 asleep, 2 driving, 3 waiting for sync
  int m_st = 0, m_ms = 0, m_us = 0, m_try = 0;
  bit m_pend = 0, m_wf = 0, m_to = 0, m_if = 0;

  always #5 clk = ~clk;

  lin_slave_sleep_wake #(
    .MS_PER_S(MSS), .SYNC_WAIT_MS(SW), .REPEAT_BASE_MS(RB),
    .REPEAT_STEP_MS(RS), .MAX_TRIES(MT), .LEN_W(3)
  ) u_lin_slave_sleep_wake (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .tick_50us(tick_50us),
    .bus_active(bus_active), .sync_seen(sync_seen), .wake_req_set(wake_req_set),
    .sleep_set(sleep_set), .flag_clear(flag_clear), .idle_sel(idle_sel),
    .repeat_sel(repeat_sel), .wake_len(wake_len), .bus_drive_low(bus_drive_low),
    .sleep(sleep), .wake_pend(wake_pend), .wake_flag(wake_flag),
    .timeout_flag(timeout_flag), .idle_flag(idle_flag)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ms = 0; m_us = 0; m_try = 0;
      m_pend = 0; m_wf = 0; m_to = 0; m_if = 0;
    end else begin
      int nx, elapsed, idle_n, rep_n;
      bit swf, sto, sif, endp;
      nx = m_st; swf = 0; sto = 0; sif = 0; endp = 0;
      elapsed = m_ms + 1;
      idle_n = (4 + 2 * int'(idle_sel)) * MSS;
      rep_n = RB + RS * int'(repeat_sel);
      if (m_st == 0) begin
        if (m_pend) begin nx = 2; swf = 1; end
        else if (sleep_set) nx = 1;
        else if (!bus_active && tick_ms && elapsed == idle_n) begin nx = 1; sif = 1; end
      end else if (m_st == 1) begin
        if (bus_active) begin nx = 0; swf = 1; end
        else if (m_pend) begin nx = 2; swf = 1; end
      end else if (m_st == 2) begin
        if (tick_50us && m_us == int'(wake_len)) begin nx = 3; endp = 1; end
      end else begin
        if (sync_seen) nx = 0;
        else if (tick_ms) begin
          if (elapsed == SW) begin sto = 1; if (m_try == MT) nx = 1; end
          if (elapsed == rep_n && m_try != MT) begin nx = 2; swf = 1; end
        end
      end
      if (nx == 2 && m_st != 2) m_try = (m_st == 3) ? m_try + 1 : 1;
      if (endp) m_pend = 0;
      else if (wake_req_set && m_st < 2) m_pend = 1;
      m_wf = swf | (m_wf & !flag_clear);
      m_to = sto | (m_to & !flag_clear);
      m_if = sif | (m_if & !flag_clear);
      if (nx != m_st || (m_st == 0 && bus_active)) m_ms = 0;
      else if (tick_ms) m_ms = elapsed;
      if (m_st != 2 || nx != 2) m_us = 0;
      else if (tick_50us) m_us = m_us + 1;
      m_st = nx;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    tick_50us = (cyc % 2 == 0);
    tick_ms = (cyc % 8 == 3);
    if (bus_active) ms_n = 0;
    else if (tick_ms) ms_n++;
    if (tick_50us) us_n++;
    cyc++;
    @(posedge clk);
    @(negedge clk);
    if (rst_n) begin
      chk(bus_drive_low == (m_st == 2), "R6 bus_drive_low", bus_drive_low, m_st == 2);
      chk(sleep == (m_st == 1), "R4 sleep", sleep, m_st == 1);
      chk(wake_pend == m_pend, "R11 wake_pend", wake_pend, m_pend);
      chk(wake_flag == m_wf, "R5 wake_flag", wake_flag, m_wf);
      chk(timeout_flag == m_to, "R8 timeout_flag", timeout_flag, m_to);
      chk(idle_flag == m_if, "R2 idle_flag", idle_flag, m_if);
    end
  endtask

  task automatic pulse_in(ref logic sig);
    sig = 1'b1; step(); sig = 1'b0;
  endtask

  initial begin
    int to_at;
    bit drove;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk({bus_drive_low, sleep, wake_pend, wake_flag, timeout_flag, idle_flag} == 6'd0,
        "R1 reset outputs", {bus_drive_low, sleep, wake_pend, wake_flag, timeout_flag, idle_flag}, 0);

    // R2: each idle-table entry
    for (int s = 0; s < 4; s++) begin
      idle_sel = 2'(s);
      pulse_in(bus_active);
      for (int g = 0; g < 3000 && !idle_flag; g++) step();
      chk(ms_n == (4 + 2 * s) * MSS, "R2 idle ticks", ms_n, (4 + 2 * s) * MSS);
      chk(sleep == 1'b1, "R2 sleep after idle", sleep, 1);
      pulse_in(flag_clear);
      chk(idle_flag == 1'b0, "R10 idle flag cleared", idle_flag, 0);
    end

    // R5: received wakeup
    pulse_in(bus_active);
    chk(!sleep && wake_flag, "R5 wake on activity", {sleep, wake_flag}, 1);

    // R3: activity restarts the count
    idle_sel = 2'd1;
    pulse_in(flag_clear);
    for (int g = 0; g < 3000 && ms_n < 30; g++) step();
    pulse_in(bus_active);
    for (int g = 0; g < 3000 && !idle_flag; g++) step();
    chk(ms_n == 60, "R3 idle restart", ms_n, 60);

    // R4: software sleep, no idle timeout while asleep
    pulse_in(bus_active);
    pulse_in(flag_clear);
    pulse_in(sleep_set);
    chk(sleep == 1'b1, "R4 sleep_set", sleep, 1);
    for (int g = 0; g < 3000 && ms_n < 120; g++) step();
    chk(idle_flag == 1'b0 && sleep, "R4 no idle while asleep", idle_flag, 0);

    // R6, R7, R11: pulse length, sync cancel, ignored request
    idle_sel = 2'd3;
    wake_len = 3'd2;
    pulse_in(flag_clear);
    pulse_in(wake_req_set);
    chk(wake_pend == 1'b1 && !bus_drive_low, "R6 pend before pulse", wake_pend, 1);
    step();
    chk(bus_drive_low == 1'b1, "R6 pulse starts", bus_drive_low, 1);
    chk(wake_flag == 1'b1, "R6 wake flag on send", wake_flag, 1);
    us_n = 0;
    wake_req_set = 1'b1;
    step();
    wake_req_set = 1'b0;
    for (int g = 0; g < 200 && bus_drive_low; g++) step();
    chk(us_n == 3, "R6 pulse length", us_n, 3);
    chk(wake_pend == 1'b0, "R6 pend self-clears", wake_pend, 0);
    ms_n = 0;
    for (int g = 0; g < 200 && ms_n < 5; g++) step();
    pulse_in(sync_seen);
    chk(!sleep && !timeout_flag, "R7 sync returns awake", {sleep, timeout_flag}, 0);
    drove = 1'b0;
    for (int g = 0; g < 3000 && ms_n < 45; g++) begin
      step();
      if (bus_drive_low || wake_pend) drove = 1'b1;
    end
    chk(!drove, "R7 R11 no further pulse", drove, 0);

    // R8, R9: retries without sync, then sleep
    repeat_sel = 2'd1;
    wake_len = 3'd0;
    pulse_in(flag_clear);
    pulse_in(wake_req_set);
    for (int p = 1; p <= MT; p++) begin
      for (int g = 0; g < 200 && !bus_drive_low; g++) step();
      for (int g = 0; g < 200 && bus_drive_low; g++) step();
      ms_n = 0;
      to_at = -1;
      for (int g = 0; g < 3000 && !bus_drive_low && !sleep; g++) begin
        step();
        if (timeout_flag && to_at < 0) to_at = ms_n;
      end
      if (p == 1) chk(to_at == SW, "R8 sync-wait timeout", to_at, SW);
      if (p < MT) chk(bus_drive_low && ms_n == RB + RS, "R9 repeat interval", ms_n, RB + RS);
      else chk(sleep && ms_n == SW, "R9 sleep after last try", ms_n, SW);
    end

    // R10: set wins over clear in the same cycle
    bus_active = 1'b1;
    flag_clear = 1'b1;
    step();
    bus_active = 1'b0;
    flag_clear = 1'b0;
    chk(wake_flag && !timeout_flag, "R10 set beats clear", {wake_flag, timeout_flag}, 2);

    step();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule